// File: doc/BRIEF.md
# Iterative Sequential Integer Divider

This block computes the quotient or the remainder of two integers, signed or unsigned. It works through the operand a few bits per clock by restoring shift-and-subtract. It is meant to sit beside the execute stage of a pipelined core. A one-cycle start request loads the operands and the operation code. From the next cycle a busy signal holds the pipeline stalled while a control state machine steps through the quotient bits. A one-cycle done pulse then presents the registered result.

Two parameters set the shape of the block. `WIDTH` is the operand and result width, 32 by default. `BPC` is the number of quotient bits produced in each compute cycle: 1, 2 or 4. The subtract step is replicated `BPC` times within one cycle, so the number of compute cycles is `WIDTH/BPC`.

For signed operations the block divides the magnitudes of the operands and then restores the signs. Division by zero and the single signed overflow case give fixed, defined results instead of a trap.

Top module: `seq_divider`

## Requirements
- R1: With `op` = 2'b01 (unsigned quotient), `result` is floor(dividend / divisor), with both operands read as unsigned and the divisor nonzero.
- R2: With `op` = 2'b11 (unsigned remainder), `result` is dividend mod divisor, with both operands read as unsigned and the divisor nonzero.
- R3: With `op` = 2'b00 (signed quotient), `result` is the two's-complement quotient rounded toward zero. It is negative exactly when the operand signs differ and the quotient is nonzero.
- R4: With `op` = 2'b10 (signed remainder), `result` satisfies dividend = quotient*divisor + remainder. The remainder carries the sign of the dividend or is zero.
- R5: For a zero divisor, a quotient operation (`op[1]`=0) returns all ones and a remainder operation (`op[1]`=1) returns the dividend unchanged. This holds for signed and unsigned operations alike.
- R6: For a signed operation with the dividend equal to the most negative value and the divisor equal to -1, the quotient is the dividend and the remainder is zero.
- R7: A start that is accepted raises `busy` in the next cycle. `busy` then stays high for exactly `WIDTH/BPC + 1` cycles. In the cycle after the last of these, `done` is high for one cycle, `busy` is low and `result` is valid.
- R8: A start request is taken only while `busy` is low. A request made while `busy` is high changes neither the result nor the timing of the operation in progress, and produces no extra done pulse.
- R9: `result` holds its value in every cycle in which `done` is low.
- R10: While synchronous reset is high, and in the first cycle after it, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Bit 0: unsigned when 1; bit 1: remainder when 1 |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| busy | output | 1 | Stall toward the pipeline while an operation runs |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | WIDTH | Quotient or remainder, held until the next done |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. `busy` is already low while `done` is high, so a new request in the done cycle must be accepted without losing the result being presented. The bench provokes this on every operation of an exhaustive sweep over all operation codes and all operand pairs of a 6-bit, two-bits-per-cycle instance. Each new request is issued in the very cycle whose done pulse it has just judged. The result is compared with an arithmetic model, and the cycle count of the next operation is checked against the fixed latency.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  // op field layout
  localparam int OPB_UNSIGNED = 0;
  localparam int OPB_REMAIN   = 1;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] dvd,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] mag_dvd,
  output logic [WIDTH-1:0] mag_dvs,
  output logic             neg_quo,
  output logic             neg_rem,
  output logic             dvs_zero,
  output logic             ovf
);
  import div_pkg::*;
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic is_signed, dvd_neg, dvs_neg;

  always_comb begin
    is_signed = ~op[OPB_UNSIGNED];
    dvd_neg   = is_signed & dvd[WIDTH-1];
    dvs_neg   = is_signed & dvs[WIDTH-1];
    mag_dvd   = dvd_neg ? (~dvd + 1'b1) : dvd;
    mag_dvs   = dvs_neg ? (~dvs + 1'b1) : dvs;
    neg_quo   = dvd_neg ^ dvs_neg;
    neg_rem   = dvd_neg;
    dvs_zero  = (dvs == '0);
    ovf       = is_signed & (dvd == MOST_NEG) & (dvs == '1);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] rem_in,
  input  logic [WIDTH-1:0] quo_in,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] rem_out,
  output logic [WIDTH-1:0] quo_out
);
  logic [WIDTH:0]   shifted;
  logic [WIDTH+1:0] diff;
  logic             take;

  always_comb begin
    shifted = {rem_in, quo_in[WIDTH-1]};
    diff    = {1'b0, shifted} - {2'b00, dvs};
    take    = ~diff[WIDTH+1];
    rem_out = take ? diff[WIDTH-1:0] : shifted[WIDTH-1:0];
    quo_out = {quo_in[WIDTH-2:0], take};
  end
endmodule

// File: rtl/div_unrolled.sv
module div_unrolled #(
  parameter int WIDTH = 32,
  parameter int BPC   = 1
) (
  input  logic [WIDTH-1:0] rem_in,
  input  logic [WIDTH-1:0] quo_in,
  input  logic [WIDTH-1:0] dvs,
  output logic [WIDTH-1:0] rem_out,
  output logic [WIDTH-1:0] quo_out
);
  logic [WIDTH-1:0] rem_c [BPC+1];
  logic [WIDTH-1:0] quo_c [BPC+1];

  assign rem_c[0] = rem_in;
  assign quo_c[0] = quo_in;

  for (genvar g = 0; g < BPC; g++) begin : g_step
    div_step #(.WIDTH(WIDTH)) u_step (
      .rem_in (rem_c[g]),
      .quo_in (quo_c[g]),
      .dvs    (dvs),
      .rem_out(rem_c[g+1]),
      .quo_out(quo_c[g+1])
    );
  end

  assign rem_out = rem_c[BPC];
  assign quo_out = quo_c[BPC];
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] quo,
  input  logic [WIDTH-1:0] rem,
  input  logic [WIDTH-1:0] orig_dvd,
  input  logic             want_rem,
  input  logic             neg_quo,
  input  logic             neg_rem,
  input  logic             dvs_zero,
  input  logic             ovf,
  output logic [WIDTH-1:0] res
);
  logic [WIDTH-1:0] q_s, r_s;

  always_comb begin
    q_s = neg_quo ? (~quo + 1'b1) : quo;
    r_s = neg_rem ? (~rem + 1'b1) : rem;
    if (dvs_zero)      res = want_rem ? orig_dvd : '1;
    else if (ovf)      res = want_rem ? '0 : orig_dvd;
    else               res = want_rem ? r_s : q_s;
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int WIDTH = 32,
  parameter int BPC   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  import div_pkg::*;

  localparam int STEPS = WIDTH / BPC;
  localparam int CNT_W = $clog2(STEPS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  initial begin
    if (WIDTH % BPC != 0 || !(BPC == 1 || BPC == 2 || BPC == 4))
      $error("seq_divider: BPC must be 1, 2 or 4 and divide WIDTH");
  end

  div_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [WIDTH-1:0] rem_q, quo_q, dvs_q, dvd_q;
  logic             want_rem_q, neg_quo_q, neg_rem_q, zero_q, ovf_q;

  logic [WIDTH-1:0] mag_dvd, mag_dvs, rem_nx, quo_nx, fixed;
  logic             neg_quo, neg_rem, dvs_zero, ovf;

  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op      (op),
    .dvd     (dividend),
    .dvs     (divisor),
    .mag_dvd (mag_dvd),
    .mag_dvs (mag_dvs),
    .neg_quo (neg_quo),
    .neg_rem (neg_rem),
    .dvs_zero(dvs_zero),
    .ovf     (ovf)
  );

  div_unrolled #(.WIDTH(WIDTH), .BPC(BPC)) u_iter (
    .rem_in (rem_q),
    .quo_in (quo_q),
    .dvs    (dvs_q),
    .rem_out(rem_nx),
    .quo_out(quo_nx)
  );

  div_result_fix #(.WIDTH(WIDTH)) u_fix (
    .quo     (quo_q),
    .rem     (rem_q),
    .orig_dvd(dvd_q),
    .want_rem(want_rem_q),
    .neg_quo (neg_quo_q),
    .neg_rem (neg_rem_q),
    .dvs_zero(zero_q),
    .ovf     (ovf_q),
    .res     (fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      rem_q      <= '0;
      quo_q      <= '0;
      dvs_q      <= '0;
      dvd_q      <= '0;
      want_rem_q <= 1'b0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      zero_q     <= 1'b0;
      ovf_q      <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          done <= 1'b0;
          if (start) begin
            rem_q      <= '0;
            quo_q      <= mag_dvd;
            dvs_q      <= mag_dvs;
            dvd_q      <= dividend;
            want_rem_q <= op[OPB_REMAIN];
            neg_quo_q  <= neg_quo;
            neg_rem_q  <= neg_rem;
            zero_q     <= dvs_zero;
            ovf_q      <= ovf;
            cnt        <= '0;
            busy       <= 1'b1;
            state      <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q <= rem_nx;
          quo_q <= quo_nx;
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN: begin
          result <= fixed;
          done   <= 1'b1;
          busy   <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 32,
  parameter int BPC   = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int STEPS = WIDTH / BPC;

  logic [15:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R7
  accept_raises_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  // R7
  busy_length_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_len == 16'(STEPS + 1)));

  // R8
  single_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));
endmodule

bind seq_divider div_checker #(.WIDTH(WIDTH), .BPC(BPC)) u_div_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done),
  .result(result)
);

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int SW = 6, SB = 2, SSTEPS = SW / SB;
  localparam int WW = 32, WB = 4, WSTEPS = WW / WB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  // small, swept instance
  logic          s_start = 1'b0;
  logic [1:0]    s_op = '0;
  logic [SW-1:0] s_a = '0, s_b = '0;
  logic          s_busy, s_done;
  logic [SW-1:0] s_res;

  seq_divider #(.WIDTH(SW), .BPC(SB)) i_seq_divider (
    .clk(clk), .rst(rst), .start(s_start), .op(s_op),
    .dividend(s_a), .divisor(s_b),
    .busy(s_busy), .done(s_done), .result(s_res)
  );

  // full-width instance
  logic          w_start = 1'b0;
  logic [1:0]    w_op = '0;
  logic [WW-1:0] w_a = '0, w_b = '0;
  logic          w_busy, w_done;
  logic [WW-1:0] w_res;

  seq_divider #(.WIDTH(WW), .BPC(WB)) i_seq_divider_wide (
    .clk(clk), .rst(rst), .start(w_start), .op(w_op),
    .dividend(w_a), .divisor(w_b),
    .busy(w_busy), .done(w_done), .result(w_res)
  );

  function automatic longint model(int w, logic [1:0] op, longint a, longint b);
    longint mask = (longint'(1) << w) - 1;
    longint sa = a[w-1] ? a - (longint'(1) << w) : a;
    longint sb = b[w-1] ? b - (longint'(1) << w) : b;
    if (b == 0) return op[1] ? a : mask;
    if (op[0]) return op[1] ? (a % b) : (a / b);
    if (sa == -(longint'(1) << (w-1)) && sb == -1) return op[1] ? 0 : a;
    return (op[1] ? (sa % sb) : (sa / sb)) & mask;
  endfunction

  function automatic string tag(int w, logic [1:0] op, longint a, longint b);
    if (b == 0) return "R5";
    if (!op[0] && a == (longint'(1) << (w-1)) && b == (longint'(1) << w) - 1) return "R6";
    case (op)
      2'b01:   return "R1";
      2'b11:   return "R2";
      2'b00:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where done is high
  task automatic run_small(logic [1:0] op, logic [SW-1:0] a, logic [SW-1:0] b);
    int n = 0;
    s_start = 1'b1; s_op = op; s_a = a; s_b = b;
    @(negedge clk);
    s_start = 1'b0;
    check("R7 busy", longint'(s_busy), 1);
    while (!s_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R7 latency", n, SSTEPS + 1);
    check(tag(SW, op, a, b), longint'(s_res), model(SW, op, a, b));
  endtask

  task automatic run_wide(logic [1:0] op, logic [WW-1:0] a, logic [WW-1:0] b);
    int n = 0;
    w_start = 1'b1; w_op = op; w_a = a; w_b = b;
    @(negedge clk);
    w_start = 1'b0;
    while (!w_done && n < 100) begin
      @(negedge clk);
      n++;
    end
    check("R7 wide latency", n, WSTEPS + 1);
    check(tag(WW, op, a, b), longint'(w_res), model(WW, op, a, b));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 during reset
    check("R10 busy", longint'(s_busy | w_busy), 0);
    check("R10 done", longint'(s_done | w_done), 0);
    check("R10 result", longint'(s_res) + longint'(w_res), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R10 after", longint'({s_busy, s_done, w_busy, w_done}), 0);

    // exhaustive sweep, back-to-back starts in the done cycle
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < (1 << SW); a++)
        for (int b = 0; b < (1 << SW); b++)
          run_small(2'(op), SW'(a), SW'(b));

    // full-width directed cases
    run_wide(2'b01, 32'hFFFF_FFFF, 32'h0000_0003);   // R1
    run_wide(2'b11, 32'hFFFF_FFFF, 32'h0000_0007);   // R2
    run_wide(2'b00, 32'hFFFF_FF85, 32'h0000_0007);   // R3 -123/7
    run_wide(2'b00, 32'h7FFF_FFFF, 32'hFFFF_FFFE);   // R3
    run_wide(2'b10, 32'hFFFF_FF85, 32'h0000_0007);   // R4
    run_wide(2'b10, 32'h0000_007B, 32'hFFFF_FFF9);   // R4
    run_wide(2'b00, 32'h1234_5678, 32'h0000_0000);   // R5
    run_wide(2'b11, 32'h1234_5678, 32'h0000_0000);   // R5
    run_wide(2'b00, 32'h8000_0000, 32'hFFFF_FFFF);   // R6
    run_wide(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);   // R6
    run_wide(2'b01, 32'h8000_0000, 32'hFFFF_FFFF);   // R1 unsigned, no overflow rule

    // R8: start while busy is ignored
    begin
      int n = 0;
      int dones = 0;
      w_start = 1'b1; w_op = 2'b01; w_a = 32'd1000; w_b = 32'd7;
      @(negedge clk);
      w_start = 1'b0;
      @(negedge clk);
      n++;
      w_start = 1'b1; w_op = 2'b11; w_a = 32'd999; w_b = 32'd5;
      @(negedge clk);
      n++;
      w_start = 1'b0;
      while (!w_done && n < 100) begin
        @(negedge clk);
        n++;
      end
      check("R8 latency", n, WSTEPS + 1);
      check("R8 result", longint'(w_res), 142);
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (w_done) dones++;
        check("R9 hold", longint'(w_res), 142);
      end
      check("R8 no extra done", dones, 0);
      check("R8 idle", longint'(w_busy), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule